// File: doc/BRIEF.md
# DMA-Error Gated Interrupt Status Unit

This unit gathers interrupt sources for an I/O controller into one 32-bit status word and drives a single CPU interrupt line from it. The status word has two kinds of bits. The low bits mirror external device request lines. They are read-only and drop on their own when the device withdraws its request. A second group of bits records DMA faults. When a DMA channel reports a memory-read error, its fault bit latches, the faulting memory address is stored, and the channel's run enable goes low in the same clock edge.

A latched fault bit has two roles. It is an interrupt source, and it is also the hold signal for its DMA channel. Software acknowledges faults by writing the status word. A zero written at a fault position clears that bit. A one leaves the bit as it is. One write can therefore acknowledge any chosen set of faults without reading the register first. Clearing a fault bit removes its interrupt contribution and releases the channel in the same edge. A read/write mask selects which status bits may reach the CPU interrupt line.

Top module: `irq_dma_gate`

## Requirements
- R1: After a synchronous reset, the status word and the mask read as zero, every `dma_run` bit is 1, and `cpu_irq` is 0.
- R2: A pulse on `dma_err[c]` sets status bit DMA_BASE+c and drives `dma_run[c]` low at the same clock edge. With the defaults, channel 0 uses bit 16 and channels 1 to 3 use bits 17 to 19.
- R3: A fault bit stays set after its `dma_err` input returns low. It stays set until software clears it.
- R4: A write of the status word (register offset 0) clears every fault bit written as 0. Fault bits written as 1 keep their value. Several faults can be cleared in one write.
- R5: Software can never set a status bit. Writing 1 to a clear fault bit leaves it 0. Writes have no effect on external-request bits.
- R6: Clearing a fault bit raises `dma_run` for that channel at the same edge. It also withdraws that bit's contribution to `cpu_irq` at the same edge.
- R7: The address on a channel's slice of `dma_err_addr` is captured when the fault latches. It reads back at register offset 2+c.
- R8: Status bits 0 to NUM_EXT-1 follow `ext_irq` one clock edge after the input changes.
- R9: `cpu_irq` is registered and equals the OR of (status AND mask) at every edge. The mask is at register offset 1. The mask has no effect on the status bits or on `dma_run`.
- R10: When a new fault and a software clear hit the same bit in the same cycle, the fault wins. The bit stays set, and the stored address is the one from the new fault.
- R11: `reg_rdata` is registered. It shows the register selected by `reg_addr` one edge after the address is presented. Unused offsets and unused status bits read as zero.
- R12: A further fault on a channel whose bit is already set does not replace the stored address. The first fault's address is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq | input | NUM_EXT | External device request levels |
| dma_err | input | NUM_DMA | Per-channel memory-read fault pulse |
| dma_err_addr | input | NUM_DMA*ADDR_W | Per-channel faulting address; channel c at bits [c*ADDR_W +: ADDR_W] |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset: 0 status, 1 mask, 2+c fault address of channel c |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| dma_run | output | NUM_DMA | Per-channel DMA run enable |
| cpu_irq | output | 1 | Registered interrupt request to the CPU |

## Verification
A fault flag that is stuck or lost shows up at the edge after the stimulus. The channel's `dma_run` bit takes the wrong value there. `cpu_irq` is also wrong whenever the mask lets that bit through. A wrong stored address or a wrong mask value only appears when its register is read, one edge after the read address is presented. For that reason the bench reads every fault address back after the stimulus table has run. Set-versus-clear ordering errors and overwrite errors show as a wrong bit or a wrong address at the next read of status or of the address register.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  // Register offsets on the local register bus
  localparam int OFS_STATUS  = 0;
  localparam int OFS_MASK    = 1;
  localparam int OFS_ERRADR0 = 2;
endpackage

// File: rtl/irqg_ext_track.sv
module irqg_ext_track #(
  parameter int NUM_EXT = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EXT-1:0] ext_irq,
  output logic [NUM_EXT-1:0] lvl_q,
  output logic [NUM_EXT-1:0] lvl_nxt
);
  // Level-following request bits: no software path can touch them
  assign lvl_nxt = ext_irq;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl_nxt;
  end
endmodule

// File: rtl/irqg_err_bit.sv
module irqg_err_bit #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_evt,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              clr_req,
  output logic              flag_q,
  output logic              flag_nxt,
  output logic [ADDR_W-1:0] addr_q
);
  // Hardware set has priority over a software clear in the same cycle
  assign flag_nxt = err_evt | (flag_q & ~clr_req);

  // Address loads only when this event starts a new fault record
  logic load_addr;
  assign load_addr = err_evt & (~flag_q | clr_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      addr_q <= '0;
    end else begin
      flag_q <= flag_nxt;
      if (load_addr) addr_q <= err_addr;
    end
  end
endmodule

// File: rtl/irqg_regfile.sv
module irqg_regfile
  import irqg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int NUM_DMA  = 4,
  parameter int DMA_BASE = 16,
  parameter int REG_AW   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  input  logic [DATA_W-1:0]         status_q,
  input  logic [NUM_DMA*ADDR_W-1:0] err_addrs,
  output logic [NUM_DMA-1:0]        clr_req,
  output logic [DATA_W-1:0]         mask_q,
  output logic [DATA_W-1:0]         mask_nxt,
  output logic [DATA_W-1:0]         reg_rdata
);
  logic wr_status, wr_mask;
  assign wr_status = reg_we && (reg_addr == REG_AW'(OFS_STATUS));
  assign wr_mask   = reg_we && (reg_addr == REG_AW'(OFS_MASK));

  // Write-zero-to-clear: a 0 at a fault position requests a clear
  for (genvar c = 0; c < NUM_DMA; c++) begin : g_clr
    assign clr_req[c] = wr_status & ~reg_wdata[DMA_BASE+c];
  end

  assign mask_nxt = wr_mask ? reg_wdata : mask_q;

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == REG_AW'(OFS_STATUS)) rd_mux = status_q;
    if (reg_addr == REG_AW'(OFS_MASK))   rd_mux = mask_q;
    for (int c = 0; c < NUM_DMA; c++) begin
      if (reg_addr == REG_AW'(OFS_ERRADR0 + c))
        rd_mux[ADDR_W-1:0] = err_addrs[c*ADDR_W +: ADDR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      reg_rdata <= '0;
    end else begin
      mask_q    <= mask_nxt;
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_dma_gate.sv
module irq_dma_gate #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 32,
  parameter int NUM_EXT  = 16,
  parameter int NUM_DMA  = 4,
  parameter int DMA_BASE = 16,
  localparam int REG_AW  = $clog2(NUM_DMA + 2)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_EXT-1:0]        ext_irq,
  input  logic [NUM_DMA-1:0]        dma_err,
  input  logic [NUM_DMA*ADDR_W-1:0] dma_err_addr,
  input  logic                      reg_we,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  output logic [NUM_DMA-1:0]        dma_run,
  output logic                      cpu_irq
);
  initial begin
    if (NUM_EXT > DMA_BASE || DMA_BASE + NUM_DMA > DATA_W || ADDR_W > DATA_W)
      $error("irq_dma_gate: bad field layout parameters");
  end

  logic [NUM_EXT-1:0]        ext_q, ext_nxt;
  logic [NUM_DMA-1:0]        flag_q, flag_nxt, clr_req;
  logic [NUM_DMA*ADDR_W-1:0] err_addrs;
  logic [DATA_W-1:0]         status_q, status_nxt, mask_q, mask_nxt;
  logic                      irq_q;

  irqg_ext_track #(.NUM_EXT(NUM_EXT)) u_ext (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .lvl_q(ext_q), .lvl_nxt(ext_nxt)
  );

  for (genvar c = 0; c < NUM_DMA; c++) begin : g_ch
    irqg_err_bit #(.ADDR_W(ADDR_W)) u_err (
      .clk     (clk),
      .rst     (rst),
      .err_evt (dma_err[c]),
      .err_addr(dma_err_addr[c*ADDR_W +: ADDR_W]),
      .clr_req (clr_req[c]),
      .flag_q  (flag_q[c]),
      .flag_nxt(flag_nxt[c]),
      .addr_q  (err_addrs[c*ADDR_W +: ADDR_W])
    );
  end

  always_comb begin
    status_q   = '0;
    status_nxt = '0;
    status_q[NUM_EXT-1:0]          = ext_q;
    status_nxt[NUM_EXT-1:0]        = ext_nxt;
    status_q[DMA_BASE +: NUM_DMA]   = flag_q;
    status_nxt[DMA_BASE +: NUM_DMA] = flag_nxt;
  end

  irqg_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_DMA(NUM_DMA),
    .DMA_BASE(DMA_BASE), .REG_AW(REG_AW)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .status_q (status_q),
    .err_addrs(err_addrs),
    .clr_req  (clr_req),
    .mask_q   (mask_q),
    .mask_nxt (mask_nxt),
    .reg_rdata(reg_rdata)
  );

  // Interrupt line registered from next-state values so it moves with status
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(status_nxt & mask_nxt);
  end

  assign cpu_irq = irq_q;
  assign dma_run = ~flag_q;
endmodule

// File: rtl/irqg_checker.sv
module irqg_checker #(
  parameter int DATA_W   = 32,
  parameter int NUM_DMA  = 4,
  parameter int DMA_BASE = 16,
  parameter int REG_AW   = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DMA-1:0] dma_err,
  input logic [NUM_DMA-1:0] dma_run,
  input logic               cpu_irq,
  input logic               reg_we,
  input logic [REG_AW-1:0]  reg_addr,
  input logic [NUM_DMA-1:0] dma_wdata,
  input logic [DATA_W-1:0]  status_q,
  input logic [DATA_W-1:0]  mask_q
);
  logic stat_wr;
  assign stat_wr = reg_we && (reg_addr == '0);

  // R9: interrupt line equals masked OR of status
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_irq == |(status_q & mask_q));

  for (genvar c = 0; c < NUM_DMA; c++) begin : g_prop
    // R2: fault latches and halts the channel
    assert_err_halts_R2: assert property (@(posedge clk) disable iff (rst)
      dma_err[c] |=> (!dma_run[c] && status_q[DMA_BASE+c]));

    // R3: fault bit persists without a clearing write
    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      (status_q[DMA_BASE+c] && !(stat_wr && !dma_wdata[c])) |=> status_q[DMA_BASE+c]);

    // R5: no set without a hardware fault
    assert_no_sw_set_R5: assert property (@(posedge clk) disable iff (rst)
      (!status_q[DMA_BASE+c] && !dma_err[c]) |=> !status_q[DMA_BASE+c]);

    // R6: channel release only through reset or a clearing write
    assert_run_release_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(dma_run[c]) |-> ($past(rst) || $past(stat_wr && !dma_wdata[c])));
  end
endmodule

bind irq_dma_gate irqg_checker #(
  .DATA_W(DATA_W), .NUM_DMA(NUM_DMA), .DMA_BASE(DMA_BASE), .REG_AW(REG_AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dma_err  (dma_err),
  .dma_run  (dma_run),
  .cpu_irq  (cpu_irq),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .dma_wdata(reg_wdata[DMA_BASE +: NUM_DMA]),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/test_irq_dma_gate.sv
module test_irq_dma_gate;
  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int VW  = 93;
  localparam int NV  = 15;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     ext_irq = '0;
  logic [NCH-1:0]  dma_err = '0;
  logic [NCH*AW-1:0] dma_err_addr = '0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCH-1:0]  dma_run;
  logic            cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_dma_gate i_irq_dma_gate (
    .clk(clk), .rst(rst), .ext_irq(ext_irq), .dma_err(dma_err),
    .dma_err_addr(dma_err_addr), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_run(dma_run),
    .cpu_irq(cpu_irq)
  );

  // {ext, err, we, addr, wdata, exp_status, exp_run, exp_irq}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h0001, 4'h0, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0001, 4'hF, 1'b0}, // R8
    {16'h0001, 4'h0, 1'b1, 3'd1, 32'h000F_0001, 32'h0000_0001, 4'hF, 1'b1}, // R9
    {16'h0000, 4'h1, 1'b0, 3'd0, 32'h0000_0000, 32'h0001_0000, 4'hE, 1'b1}, // R2
    {16'h0000, 4'h0, 1'b0, 3'd0, 32'h0000_0000, 32'h0001_0000, 4'hE, 1'b1}, // R3
    {16'h0000, 4'h0, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0001_0000, 4'hE, 1'b1}, // R4
    {16'h0000, 4'hA, 1'b0, 3'd0, 32'h0000_0000, 32'h000B_0000, 4'h4, 1'b1}, // R2
    {16'h0000, 4'h0, 1'b1, 3'd0, 32'hFFFD_FFFF, 32'h0009_0000, 4'h6, 1'b1}, // R4
    {16'h0000, 4'h0, 1'b1, 3'd0, 32'h0000_0000, 32'h0000_0000, 4'hF, 1'b0}, // R6
    {16'h0000, 4'h0, 1'b1, 3'd0, 32'hFFFF_FFFF, 32'h0000_0000, 4'hF, 1'b0}, // R5
    {16'h8000, 4'h0, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_8000, 4'hF, 1'b0}, // R9
    {16'h8000, 4'h0, 1'b1, 3'd1, 32'hFFFF_FFFF, 32'h0000_8000, 4'hF, 1'b1}, // R9
    {16'h0000, 4'h0, 1'b0, 3'd0, 32'h0000_0000, 32'h0000_0000, 4'hF, 1'b0}, // R8
    {16'h0000, 4'h4, 1'b1, 3'd1, 32'h0000_0000, 32'h0004_0000, 4'hB, 1'b0}, // R9
    {16'h0000, 4'h4, 1'b1, 3'd0, 32'h0000_0000, 32'h0004_0000, 4'hB, 1'b0}, // R10
    {16'h0000, 4'h0, 1'b1, 3'd0, 32'h0000_0000, 32'h0000_0000, 4'hF, 1'b0}  // R6
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_addrs(input int tag);
    for (int c = 0; c < NCH; c++)
      dma_err_addr[c*AW +: AW] = 32'hA000_0000 + 32'(tag * 16 + c);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_we = 1'b0; dma_err = '0; reg_addr = a;
    @(posedge clk); @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_err(input int c, input logic [31:0] adr);
    dma_err_addr[c*AW +: AW] = adr;
    dma_err[c] = 1'b1;
    @(posedge clk); @(negedge clk);
    dma_err = '0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 run", 32'(dma_run), 32'hF);
    chk("R1 irq", 32'(cpu_irq), 32'h0);
    rd(3'd0, v); chk("R1 status", v, 32'h0);
    rd(3'd1, v); chk("R1 mask", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] e;
      e = VEC[i];
      ext_irq   = e[92:77];
      dma_err   = e[76:73];
      reg_we    = e[72];
      reg_addr  = e[71:69];
      reg_wdata = e[68:37];
      set_addrs(i);
      @(posedge clk); @(negedge clk);
      chk($sformatf("R2/R6 run step %0d", i), 32'(dma_run), 32'(e[4:1]));
      chk($sformatf("R9 irq step %0d", i), 32'(cpu_irq), 32'(e[0]));
      rd(3'd0, v);
      chk($sformatf("R4/R5/R8 status step %0d", i), v, e[36:5]);
    end

    // R7 captured addresses; R10 new event address wins
    rd(3'd2, v); chk("R7 addr ch0", v, 32'hA000_0020);
    rd(3'd3, v); chk("R7 addr ch1", v, 32'hA000_0051);
    rd(3'd5, v); chk("R7 addr ch3", v, 32'hA000_0053);
    rd(3'd4, v); chk("R10 addr ch2", v, 32'hA000_00D2);
    // R11 unused offsets read zero, mask readback
    rd(3'd6, v); chk("R11 unused 6", v, 32'h0);
    rd(3'd7, v); chk("R11 unused 7", v, 32'h0);
    rd(3'd1, v); chk("R11 mask", v, 32'h0);

    // R12 first fault address kept
    pulse_err(0, 32'h1111_0000);
    pulse_err(0, 32'h2222_0000);
    rd(3'd2, v); chk("R12 addr kept", v, 32'h1111_0000);
    rd(3'd0, v); chk("R12 status", v, 32'h0001_0000);
    chk("R12 run", 32'(dma_run), 32'hE);
    // R6 clear releases channel
    wr(3'd0, 32'h0);
    chk("R6 run release", 32'(dma_run), 32'hF);

    // R1 reset mid-operation
    wr(3'd1, 32'hFFFF_FFFF);
    pulse_err(3, 32'h3333_0000);
    chk("R9 irq ch3", 32'(cpu_irq), 32'h1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1 run after reset", 32'(dma_run), 32'hF);
    chk("R1 irq after reset", 32'(cpu_irq), 32'h0);
    rd(3'd0, v); chk("R1 status after reset", v, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule